// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the serial test port of a synchronous memory die. It is clocked by its own test clock and steered by a mode-select input. It carries the sixteen-state test-port controller, a three-bit instruction register, a one-bit pass-through register, a 32-bit identification register loaded from a constant, and a boundary register of configurable length. The boundary register has a capture port from the pins and a held update port toward the pins.

There is no dedicated test-reset pin. The controller returns to its reset state in two ways: on the asynchronous power-up reset, or when the mode-select input is held high for five rising test-clock edges. The decoded instruction gives the core three flags:
- a boundary-register select;
- a flag that forces all data and clock outputs to high impedance while the pins are sampled;
- a flag that tells the core to drive its data outputs from the held update cells.

The controller states are:
- `S_RESET`: the reset state.
- `S_IDLE`: the idle state.
- `S_SEL_DR`, `S_CAP_DR`, `S_SHF_DR`, `S_EX1_DR`, `S_PAU_DR`, `S_EX2_DR`, `S_UPD_DR`: select, capture, shift, exit-1, pause, exit-2 and update for the data path.
- `S_SEL_IR`, `S_CAP_IR`, `S_SHF_IR`, `S_EX1_IR`, `S_PAU_IR`, `S_EX2_IR`, `S_UPD_IR`: the same seven states for the instruction path.

Transitions follow the standard test-port graph, with mode-select 0/1 choosing the branch:
- `S_RESET` goes 0 to `S_IDLE`, 1 to itself.
- `S_IDLE` goes 0 to itself, 1 to `S_SEL_DR`.
- `S_SEL_DR` goes 0 to `S_CAP_DR`, 1 to `S_SEL_IR`.
- `S_SEL_IR` goes 0 to `S_CAP_IR`, 1 to `S_RESET`.
- Capture goes 0 to shift, 1 to exit-1.
- Shift goes 0 to itself, 1 to exit-1.
- Exit-1 goes 0 to pause, 1 to update.
- Pause goes 0 to itself, 1 to exit-2.
- Exit-2 goes 0 to shift, 1 to update.
- Update goes 0 to `S_IDLE`, 1 to `S_SEL_DR`.

Top module: `scan_port_ctrl`

## Requirements
- R1: The controller state advances on each rising test-clock edge by the transition graph above, and the power-up reset puts it in `S_RESET`.
- R2: Five consecutive rising edges with mode-select high bring the controller to `S_RESET` from any state. Four such edges from `S_SHF_DR` do not.
- R3: In the instruction capture state the instruction shift register loads binary 001, so bit 0 is shifted out first and reads 1, then 0, then 0. Shift-in enters at bit 2.
- R4: The active instruction changes only on the falling edge while in `S_UPD_IR`. It is set to the identify code 001 on power-up reset and on every falling edge spent in `S_RESET`.
- R5: The opcodes are 000 drive-from-cells, 001 identify, 010 sample-with-outputs-off, 100 sample/preload, and 011, 101, 110, 111 pass-through. The three boundary opcodes (000, 010, 100) raise `bsr_sel`.
- R6: Under the identify code, data capture loads the 32-bit `ID_CODE` constant, and its bit 0 reaches `tdo` first.
- R7: Under a pass-through opcode, data capture loads 0 into the one-bit register, so the data shifted out is 0 followed by the shifted-in bits delayed by one position.
- R8: Under a boundary opcode, data capture loads each cell from `pin_in` where `PIN_MASK` has a 1. Cells whose mask bit is 0 have no pin and load 1.
- R9: While opcode 010 is active, `force_hiz` is high. It is low under every other opcode.
- R10: `bsr_out` takes the boundary shift contents on the falling edge in `S_UPD_DR` and holds them otherwise. `extest_drive` is high only while opcode 000 is active.
- R11: `tdo` and `tdo_en` change on the falling edge. `tdo_en` is high only after a falling edge spent in `S_SHF_DR` or `S_SHF_IR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| pin_in | input | BSR_LEN | Pin levels seen by the boundary cells |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_en | output | 1 | Output enable for `tdo` |
| bsr_out | output | BSR_LEN | Held update cells toward the pins |
| bsr_sel | output | 1 | Boundary register is the selected data path |
| force_hiz | output | 1 | Core must turn data and clock outputs off |
| extest_drive | output | 1 | Core must drive data outputs from `bsr_out` |

## Verification
The assertions watch every cycle for the following:
- the five-edge return to reset;
- `tdo_en` staying low outside the two shift states;
- the instruction flags holding steady except in `S_UPD_IR` and `S_RESET`;
- the identify default in the reset state;
- the exclusivity of the output-off and drive flags.

Other behaviour can only be shown by the bench's scenarios: the captured values of each register and the bit order on `tdo`, the falling-edge timing of instruction and update-cell changes, and the four-edge boundary of the reset sequence. The bench sweeps all eight opcodes and sixteen arbitrary controller walks.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        S_RESET, S_IDLE,
        S_SEL_DR, S_CAP_DR, S_SHF_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SHF_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_DRIVE   = 3'b000,
        OP_IDENT   = 3'b001,
        OP_SAMP_OFF= 3'b010,
        OP_RSV_A   = 3'b011,
        OP_PRELOAD = 3'b100,
        OP_PRIV    = 3'b101,
        OP_RSV_B   = 3'b110,
        OP_PASS    = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        PATH_PASS,
        PATH_IDENT,
        PATH_CELLS
    } dr_path_e;

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       shf_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir
);

    tap_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_RESET:  nxt = tms ? S_RESET  : S_IDLE;
            S_IDLE:   nxt = tms ? S_SEL_DR : S_IDLE;
            S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: nxt = tms ? S_EX1_DR : S_SHF_DR;
            S_SHF_DR: nxt = tms ? S_EX1_DR : S_SHF_DR;
            S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: nxt = tms ? S_UPD_DR : S_SHF_DR;
            S_UPD_DR: nxt = tms ? S_SEL_DR : S_IDLE;
            S_SEL_IR: nxt = tms ? S_RESET  : S_CAP_IR;
            S_CAP_IR: nxt = tms ? S_EX1_IR : S_SHF_IR;
            S_SHF_IR: nxt = tms ? S_EX1_IR : S_SHF_IR;
            S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: nxt = tms ? S_UPD_IR : S_SHF_IR;
            S_UPD_IR: nxt = tms ? S_SEL_DR : S_IDLE;
            default:  nxt = S_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state <= S_RESET;
        else        state <= nxt;
    end

    always_comb begin
        in_reset = 1'b0;
        cap_dr   = 1'b0;
        shf_dr   = 1'b0;
        upd_dr   = 1'b0;
        cap_ir   = 1'b0;
        shf_ir   = 1'b0;
        upd_ir   = 1'b0;
        unique case (state)
            S_RESET:  in_reset = 1'b1;
            S_CAP_DR: cap_dr   = 1'b1;
            S_SHF_DR: shf_dr   = 1'b1;
            S_UPD_DR: upd_dr   = 1'b1;
            S_CAP_IR: cap_ir   = 1'b1;
            S_SHF_IR: shf_ir   = 1'b1;
            S_UPD_IR: upd_ir   = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/scan_port_instr.sv
module scan_port_instr
    import scan_port_pkg::*;
(
    input  logic     tck,
    input  logic     por_n,
    input  logic     tdi,
    input  logic     in_reset,
    input  logic     cap_ir,
    input  logic     shf_ir,
    input  logic     upd_ir,
    output logic     ir_lsb,
    output dr_path_e path,
    output logic     force_hiz,
    output logic     extest_drive
);

    localparam logic [IR_W-1:0] CAPTURE_PAT = 3'b001;

    logic [IR_W-1:0] ir_sr;
    opcode_e         active;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)      ir_sr <= CAPTURE_PAT;
        else if (cap_ir) ir_sr <= CAPTURE_PAT;
        else if (shf_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n)        active <= OP_IDENT;
        else if (in_reset) active <= OP_IDENT;
        else if (upd_ir)   active <= opcode_e'(ir_sr);
    end

    assign ir_lsb = ir_sr[0];

    always_comb begin
        path         = PATH_PASS;
        force_hiz    = 1'b0;
        extest_drive = 1'b0;
        unique case (active)
            OP_DRIVE: begin
                path         = PATH_CELLS;
                extest_drive = 1'b1;
            end
            OP_IDENT:    path = PATH_IDENT;
            OP_SAMP_OFF: begin
                path      = PATH_CELLS;
                force_hiz = 1'b1;
            end
            OP_PRELOAD:  path = PATH_CELLS;
            OP_RSV_A, OP_PRIV, OP_RSV_B, OP_PASS: path = PATH_PASS;
            default:     path = PATH_PASS;
        endcase
    end

endmodule

// File: rtl/scan_port_cells.sv
module scan_port_cells #(
    parameter int                 LEN  = 8,
    parameter logic [LEN-1:0]     MASK = '1
) (
    input  logic           tck,
    input  logic           por_n,
    input  logic           tdi,
    input  logic           sel,
    input  logic           cap,
    input  logic           shf,
    input  logic           upd,
    input  logic [LEN-1:0] pin_in,
    output logic           sr_lsb,
    output logic [LEN-1:0] held
);

    logic [LEN-1:0] cap_val;
    logic [LEN-1:0] sr;

    for (genvar i = 0; i < LEN; i++) begin : g_cell
        if (MASK[i]) begin : g_pin
            assign cap_val[i] = pin_in[i];
        end else begin : g_nopin
            assign cap_val[i] = 1'b1;
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)            sr <= '0;
        else if (sel && cap)   sr <= cap_val;
        else if (sel && shf)   sr <= {tdi, sr[LEN-1:1]};
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n)          held <= '0;
        else if (sel && upd) held <= sr;
    end

    assign sr_lsb = sr[0];

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_port_pkg::*;
#(
    parameter int                   BSR_LEN  = 8,
    parameter logic [BSR_LEN-1:0]   PIN_MASK = 8'hB7,
    parameter logic [31:0]          ID_CODE  = 32'h1A2B_3C4D
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic [BSR_LEN-1:0] bsr_out,
    output logic               bsr_sel,
    output logic               force_hiz,
    output logic               extest_drive
);

    tap_state_e st;
    logic       in_reset, cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir;
    logic       ir_lsb, cell_lsb, pass_bit, ser_out;
    dr_path_e   path;
    logic [ID_W-1:0] id_sr;

    scan_port_fsm fsm_i (
        .tck(tck), .por_n(por_n), .tms(tms), .state(st),
        .in_reset(in_reset), .cap_dr(cap_dr), .shf_dr(shf_dr), .upd_dr(upd_dr),
        .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir)
    );

    scan_port_instr instr_i (
        .tck(tck), .por_n(por_n), .tdi(tdi), .in_reset(in_reset),
        .cap_ir(cap_ir), .shf_ir(shf_ir), .upd_ir(upd_ir),
        .ir_lsb(ir_lsb), .path(path), .force_hiz(force_hiz),
        .extest_drive(extest_drive)
    );

    assign bsr_sel = (path == PATH_CELLS);

    scan_port_cells #(.LEN(BSR_LEN), .MASK(PIN_MASK)) cells_i (
        .tck(tck), .por_n(por_n), .tdi(tdi), .sel(bsr_sel),
        .cap(cap_dr), .shf(shf_dr), .upd(upd_dr), .pin_in(pin_in),
        .sr_lsb(cell_lsb), .held(bsr_out)
    );

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            id_sr    <= '0;
            pass_bit <= 1'b0;
        end else begin
            if (path == PATH_IDENT && cap_dr)      id_sr <= ID_CODE;
            else if (path == PATH_IDENT && shf_dr) id_sr <= {tdi, id_sr[ID_W-1:1]};
            if (path == PATH_PASS && cap_dr)       pass_bit <= 1'b0;
            else if (path == PATH_PASS && shf_dr)  pass_bit <= tdi;
        end
    end

    always_comb begin
        ser_out = pass_bit;
        if (shf_ir) ser_out = ir_lsb;
        else begin
            unique case (path)
                PATH_IDENT: ser_out = id_sr[0];
                PATH_CELLS: ser_out = cell_lsb;
                default:    ser_out = pass_bit;
            endcase
        end
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= ser_out;
            tdo_en <= shf_dr | shf_ir;
        end
    end

endmodule

// File: rtl/scan_port_ctrl_chk.sv
module scan_port_ctrl_chk
    import scan_port_pkg::*;
(
    input logic       tck,
    input logic       por_n,
    input logic       tms,
    input tap_state_e st,
    input logic       tdo_en,
    input logic       bsr_sel,
    input logic       force_hiz,
    input logic       extest_drive
);

    logic [2:0] hi_cnt;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)         hi_cnt <= '0;
        else if (!tms)      hi_cnt <= '0;
        else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
    end

    // R2
    tms_five_reset_chk: assert property (@(posedge tck) disable iff (!por_n)
        (hi_cnt >= 3'd5) |-> (st == S_RESET));

    // R11
    tdo_idle_chk: assert property (@(posedge tck) disable iff (!por_n)
        (st != S_SHF_DR && st != S_SHF_IR) |-> !tdo_en);

    // R4
    instr_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
        (st != S_UPD_IR && st != S_RESET) |-> $stable({bsr_sel, force_hiz, extest_drive}));

    // R4
    reset_ident_chk: assert property (@(posedge tck) disable iff (!por_n)
        (st == S_RESET) |-> (!bsr_sel && !force_hiz && !extest_drive));

    // R9
    hiz_excl_chk: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0({force_hiz, extest_drive}));

    // R10
    drive_cells_chk: assert property (@(posedge tck) disable iff (!por_n)
        (force_hiz || extest_drive) |-> bsr_sel);

endmodule

bind scan_port_ctrl scan_port_ctrl_chk chk_i (
    .tck(tck), .por_n(por_n), .tms(tms), .st(st), .tdo_en(tdo_en),
    .bsr_sel(bsr_sel), .force_hiz(force_hiz), .extest_drive(extest_drive)
);

// File: tb/scan_port_ctrl_tb_top.sv
module scan_port_ctrl_tb_top;

    localparam int          LEN  = 8;
    localparam logic [7:0]  MASK = 8'hB7;
    localparam logic [31:0] IDC  = 32'h1A2B_3C4D;

    logic tck = 1'b0;
    logic por_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b1;
    logic [LEN-1:0] pin_in = '0;
    logic tdo, tdo_en, bsr_sel, force_hiz, extest_drive;
    logic [LEN-1:0] bsr_out;

    int total = 0;
    int bad = 0;

    always #10 tck = ~tck;

    scan_port_ctrl #(.BSR_LEN(LEN), .PIN_MASK(MASK), .ID_CODE(IDC)) dut_i (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_en(tdo_en), .bsr_out(bsr_out), .bsr_sel(bsr_sel),
        .force_hiz(force_hiz), .extest_drive(extest_drive)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); #1;
    endtask

    bit edge_ok = 1'b1;

    // entered in a shift state just after a rising edge; leaves in exit-1
    task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            if (i > 0 && tdo !== dout[i-1]) edge_ok = 1'b0;
            @(negedge tck); #1;
            dout[i] = tdo;
            if (tdo_en !== 1'b1) edge_ok = 1'b0;
            tms = (i == n - 1); tdi = din[i];
            @(posedge tck); #1;
        end
    endtask

    task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
        logic [63:0] o;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        shift_bits(3, {61'd0, code}, o);
        cap = o[2:0];
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        step(1, 0); step(0, 0); step(0, 0);
        shift_bits(n, din, dout);
        step(1, 0); step(0, 0);
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] o;
        logic [2:0]  c;
        logic [63:0] din;
        logic [7:0]  exp8;

        #35;
        chk(tdo_en === 0 && bsr_sel === 0 && force_hiz === 0 && extest_drive === 0,
            "R4 power-up identify default", {tdo_en, bsr_sel, force_hiz, extest_drive}, 0);
        @(negedge tck); por_n = 1'b1;
        @(posedge tck); #1;
        step(0, 0);
        chk(tdo_en === 0, "R11 tdo_en low in idle", tdo_en, 0);

        scan_dr(32, 64'h0, o);
        chk(o[31:0] === IDC, "R1 R6 identify after reset", o[31:0], IDC);

        for (int op = 0; op < 8; op++) begin
            scan_ir(op[2:0], c);
            chk(c === 3'b001, "R3 instruction capture 001", c, 3'b001);
            chk(bsr_sel === (op == 0 || op == 2 || op == 4), "R5 cell path select", bsr_sel, (op == 0 || op == 2 || op == 4));
            chk(force_hiz === (op == 2), "R9 outputs-off flag", force_hiz, (op == 2));
            chk(extest_drive === (op == 0), "R10 drive flag", extest_drive, (op == 0));
            if (op == 1) begin
                scan_dr(32, 64'hFFFF_0000, o);
                chk(o[31:0] === IDC, "R6 identify constant", o[31:0], IDC);
            end else if (op == 0 || op == 2 || op == 4) begin
                pin_in = 8'h3C ^ 8'(op * 37);
                exp8 = pin_in | ~MASK;
                din = 64'(8'h96 ^ 8'(op));
                scan_dr(8, din, o);
                chk(o[7:0] === exp8, "R8 cell capture", o[7:0], exp8);
            end else begin
                din = 64'(8'hC6 ^ 8'(op));
                scan_dr(8, din, o);
                chk(o[7:0] === {din[6:0], 1'b0}, "R7 pass-through delay", o[7:0], {din[6:0], 1'b0});
            end
        end
        chk(edge_ok, "R11 tdo moves on falling edge only", edge_ok, 1);

        // preload then drive
        scan_ir(3'b100, c);
        scan_dr(8, 64'hA5, o);
        chk(bsr_out === 8'hA5, "R10 preload into held cells", bsr_out, 8'hA5);
        scan_ir(3'b000, c);
        chk(extest_drive === 1 && bsr_out === 8'hA5, "R10 drive keeps preload", {extest_drive, bsr_out}, {1'b1, 8'hA5});
        step(1, 0); step(0, 0); step(0, 0);
        shift_bits(8, 64'h5A, o);
        step(1, 0);
        chk(bsr_out === 8'hA5, "R10 held cells before falling edge", bsr_out, 8'hA5);
        @(negedge tck); #1;
        chk(bsr_out === 8'h5A, "R10 held cells after falling edge", bsr_out, 8'h5A);
        step(0, 0);

        // instruction update timing
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        shift_bits(3, 64'h1, o);
        chk(extest_drive === 1, "R4 no change before update", extest_drive, 1);
        step(1, 0);
        chk(extest_drive === 1, "R4 no change at rising edge", extest_drive, 1);
        @(negedge tck); #1;
        chk(extest_drive === 0 && bsr_sel === 0, "R4 change on falling edge", {extest_drive, bsr_sel}, 0);
        step(0, 0);

        // four highs are not enough, five are
        scan_ir(3'b010, c);
        step(1, 0); step(0, 0); step(0, 0);
        step(1, 0); step(1, 0); step(1, 0); step(1, 0);
        @(negedge tck); #1;
        chk(force_hiz === 1, "R2 four highs keep instruction", force_hiz, 1);
        step(1, 0);
        @(negedge tck); #1;
        chk(force_hiz === 0, "R2 fifth high resets", force_hiz, 0);

        for (int k = 0; k < 16; k++) begin
            step(0, 0);
            scan_ir(3'b010, c);
            for (int j = 0; j < 6; j++) begin
                logic [7:0] pat;
                pat = 8'(k * 11 + 3);
                step(pat[j], pat[(j + 1) % 8]);
            end
            for (int j = 0; j < 5; j++) step(1, 0);
            @(negedge tck); #1;
            chk(force_hiz === 0 && tdo_en === 0, "R2 reset from walked state", {force_hiz, tdo_en}, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule